// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers of a 32-bit processor core that runs in several privilege modes. A 4-bit architectural index and a 5-bit mode code select a physical register. Indices 0 to 7 are shared by every mode. Indices 8 to 12 have a second copy that only the fast-interrupt mode uses. Indices 13 (stack pointer) and 14 (link register) have a private copy for each exception mode, and system mode shares the user copies. In total there are 32 physical registers plus a program counter.

There is one combinational read port and one clocked write port, and each port carries its own index and mode. A separate program-counter port loads a branch target or advances by the instruction size. The block also takes the security-extension presence, the non-secure bit, the current mode, a lock bit that closes the fast-interrupt bank to non-secure code, and the active instruction set. From these it reports accesses that are illegal or unpredictable. A write that errors leaves all state unchanged.

Top module: `banked_regfile`

## Requirements
- R1: The legal mode codes are 10000 user, 10001 fast-interrupt, 10010 interrupt, 10011 supervisor, 10110 monitor, 10111 abort, 11011 undefined and 11111 system. Any other code raises the port's error (`rd_err_o`, or `wr_err_o` while `wr_en_i` is high). Code 10110 is also an error when `sec_ext_i` is 0.
- R2: Indices 0 to 7 select the same physical register in every legal mode.
- R3: Indices 8 to 12 select a separate copy in mode 10001 and the user copy in all other modes.
- R4: Indices 13 and 14 each have separate copies for the user, fast-interrupt, interrupt, supervisor, abort, undefined and monitor modes. System mode 11111 uses the user copy.
- R5: A read of index 15 returns the PC plus 8 when `iset_i` is 00 (the 32-bit set) and the PC plus 4 for any other `iset_i` value, and it never errors. A write to index 15 always errors.
- R6: The core is secure when `sec_ext_i` is 0, when `ns_i` is 0, or when `cur_mode_i` is 10110. When the core is not secure, an access in mode 10110 is an error, and an access in mode 10001 is an error while `fiq_lock_i` is 1.
- R7: A write to index 13 whose data has bits [1:0] not equal to 00 is an error unless `iset_i` is 00.
- R8: A write that errors changes no register. A read that errors returns zero.
- R9: A write takes effect at the clock edge. A read in the same cycle returns the old value.
- R10: `pc_ld_i` loads `pc_ld_addr_i`. Otherwise `pc_inc_i` adds 2 when `pc_narrow_i` is 1 and 4 when it is 0. Otherwise the PC holds. A load wins over an increment in the same cycle.
- R11: A synchronous active-low reset clears all 32 registers and sets the PC to `RESET_PC`, which defaults to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_ext_i | input | 1 | Security extension present |
| ns_i | input | 1 | Non-secure bit |
| cur_mode_i | input | 5 | Current processor mode |
| fiq_lock_i | input | 1 | Closes the fast-interrupt bank to non-secure code |
| iset_i | input | 2 | Active instruction set; 00 is the 32-bit set |
| rd_idx_i | input | 4 | Read index |
| rd_mode_i | input | 5 | Read mode |
| rd_data_o | output | 32 | Read data |
| rd_err_o | output | 1 | Read access error |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write index |
| wr_mode_i | input | 5 | Write mode |
| wr_data_i | input | 32 | Write data |
| wr_err_o | output | 1 | Write access error; the write is dropped |
| pc_ld_i | input | 1 | Load the PC |
| pc_ld_addr_i | input | 32 | PC load value |
| pc_inc_i | input | 1 | Advance the PC |
| pc_narrow_i | input | 1 | Increment by 2 instead of 4 |
| pc_o | output | 32 | Current PC |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a write and a read that resolve to the same physical register: the read must still show the value from before the edge. The bench provokes this on purpose, and the random mix produces it often, because modes and indices are drawn from a small set. The second pair is a PC load together with an increment, where the load must win. A read of index 15 taken in that same cycle must show the old PC plus its offset. The bench judges every cycle against a model that samples outputs before the edge and only then applies the write and the PC update.

// File: rtl/brf_pkg.sv
// Package: shared constants and types for the mode-banked register file.
// Assumes the fixed layout: 8 shared, 2x5 fast-interrupt split, 7x2 SP/LR.
package brf_pkg;
    localparam logic [4:0] MD_USR = 5'b10000;
    localparam logic [4:0] MD_FIQ = 5'b10001;
    localparam logic [4:0] MD_IRQ = 5'b10010;
    localparam logic [4:0] MD_SVC = 5'b10011;
    localparam logic [4:0] MD_MON = 5'b10110;
    localparam logic [4:0] MD_ABT = 5'b10111;
    localparam logic [4:0] MD_UND = 5'b11011;
    localparam logic [4:0] MD_SYS = 5'b11111;

    localparam int SHARED_CNT = 8;                        // indices 0..7
    localparam int FIQ_CNT    = 5;                        // indices 8..12
    localparam int BANK_CNT   = 7;                        // SP/LR owners
    localparam int FIQ_BASE   = SHARED_CNT + FIQ_CNT;     // 13
    localparam int SPLR_BASE  = FIQ_BASE + FIQ_CNT;       // 18
    localparam int PHYS_REGS  = SPLR_BASE + 2 * BANK_CNT; // 32
    localparam int PA_W       = $clog2(PHYS_REGS);
    localparam logic [3:0] IDX_SP = 4'd13;
    localparam logic [3:0] IDX_LR = 4'd14;
    localparam logic [3:0] IDX_PC = 4'd15;

    typedef enum logic [2:0] {
        BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2, BK_SVC = 3'd3,
        BK_ABT = 3'd4, BK_UND = 3'd5, BK_MON = 3'd6
    } bank_e;

    typedef logic [1:0] iset_t;
    localparam iset_t ISET_WIDE = 2'b00;
endpackage

// File: rtl/brf_mode_decode.sv
// Module: decodes a 5-bit mode code into legality and the owning SP/LR bank.
// Assumes system mode shares the user bank; monitor is legal only with the
// security extension present.
module brf_mode_decode
    import brf_pkg::*;
(
    input  logic [4:0] mode_i,
    input  logic       sec_ext_i,
    output logic       legal_o,
    output bank_e      bank_o
);
    // Mode code to bank lookup with legality
    always_comb begin
        legal_o = 1'b1;
        bank_o  = BK_USR;
        case (mode_i)
            MD_USR: bank_o = BK_USR;
            MD_FIQ: bank_o = BK_FIQ;
            MD_IRQ: bank_o = BK_IRQ;
            MD_SVC: bank_o = BK_SVC;
            MD_MON: begin bank_o = BK_MON; legal_o = sec_ext_i; end
            MD_ABT: bank_o = BK_ABT;
            MD_UND: bank_o = BK_UND;
            MD_SYS: bank_o = BK_USR;
            default: legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/brf_index_map.sv
// Module: maps an architectural index and bank onto a physical slot.
// Assumes index 15 is handled by the caller (flagged through is_pc_o).
module brf_index_map
    import brf_pkg::*;
(
    input  logic [3:0]      idx_i,
    input  bank_e           bank_i,
    output logic [PA_W-1:0] phys_o,
    output logic            is_pc_o
);
    localparam int LOW_LAST = SHARED_CNT + FIQ_CNT - 1;

    // Slot selection by index range
    always_comb begin
        is_pc_o = (idx_i == IDX_PC);
        phys_o  = PA_W'(idx_i);
        if (int'(idx_i) >= SHARED_CNT && int'(idx_i) <= LOW_LAST) begin
            if (bank_i == BK_FIQ)
                phys_o = PA_W'(int'(idx_i) - SHARED_CNT + FIQ_BASE);
        end else if (idx_i == IDX_SP || idx_i == IDX_LR) begin
            phys_o = PA_W'(SPLR_BASE + 2 * int'(bank_i) + int'(idx_i - IDX_SP));
        end else if (idx_i == IDX_PC) begin
            phys_o = '0;
        end
    end
endmodule

// File: rtl/brf_storage.sv
// Module: flat physical register array, one write and one combinational read.
// Assumes the caller has already suppressed illegal writes.
module brf_storage #(
    parameter int DW    = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] slot_q [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_slot
        // Per-slot register with reset and targeted write
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (we_i && waddr_i == AW'(g))
                slot_q[g] <= wdata_i;
        end
    end

    // Asynchronous read of the addressed slot
    assign rdata_o = slot_q[raddr_i];
endmodule

// File: rtl/brf_pc.sv
// Module: program counter with load and size-dependent increment.
// Assumes load has priority over increment.
module brf_pc #(
    parameter int            DW       = 32,
    parameter logic [DW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [DW-1:0] ld_addr_i,
    input  logic          inc_i,
    input  logic          narrow_i,
    output logic [DW-1:0] pc_o
);
    logic [DW-1:0] pc_q;

    // PC update: reset, load, increment, hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= RESET_PC;
        else if (ld_i)
            pc_q <= ld_addr_i;
        else if (inc_i)
            pc_q <= pc_q + (narrow_i ? DW'(2) : DW'(4));
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/banked_regfile.sv
// Module: top of the mode-banked register file. Combines mode decode, index
// mapping and legality checks for one read and one write port, plus the PC.
// Assumes iset_i==00 is the 32-bit instruction set, all else compact.
module banked_regfile
    import brf_pkg::*;
#(
    parameter int            DW       = 32,
    parameter logic [DW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_ext_i,
    input  logic          ns_i,
    input  logic [4:0]    cur_mode_i,
    input  logic          fiq_lock_i,
    input  logic [1:0]    iset_i,
    input  logic [3:0]    rd_idx_i,
    input  logic [4:0]    rd_mode_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_err_o,
    input  logic          wr_en_i,
    input  logic [3:0]    wr_idx_i,
    input  logic [4:0]    wr_mode_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          wr_err_o,
    input  logic          pc_ld_i,
    input  logic [DW-1:0] pc_ld_addr_i,
    input  logic          pc_inc_i,
    input  logic          pc_narrow_i,
    output logic [DW-1:0] pc_o
);
    localparam int NPORT   = 2;   // 0 = read, 1 = write
    localparam int P_RD    = 0;
    localparam int P_WR    = 1;
    localparam int OFF_W   = 8;
    localparam int OFF_N   = 4;

    logic [4:0]      port_mode [NPORT];
    logic [3:0]      port_idx  [NPORT];
    logic            port_legal[NPORT];
    bank_e           port_bank [NPORT];
    logic [PA_W-1:0] port_phys [NPORT];
    logic            port_pc   [NPORT];
    logic            port_fault[NPORT];
    logic            secure;
    logic            wr_fault;
    logic [DW-1:0]   store_rdata;

    assign port_mode[P_RD] = rd_mode_i;
    assign port_mode[P_WR] = wr_mode_i;
    assign port_idx[P_RD]  = rd_idx_i;
    assign port_idx[P_WR]  = wr_idx_i;

    // Secure when no extension, secure world, or running in monitor mode
    assign secure = !sec_ext_i || !ns_i || (cur_mode_i == MD_MON);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        brf_mode_decode u_dec (
            .mode_i    (port_mode[p]),
            .sec_ext_i (sec_ext_i),
            .legal_o   (port_legal[p]),
            .bank_o    (port_bank[p])
        );
        brf_index_map u_map (
            .idx_i   (port_idx[p]),
            .bank_i  (port_bank[p]),
            .phys_o  (port_phys[p]),
            .is_pc_o (port_pc[p])
        );
        // Mode and security fault common to both ports
        always_comb begin
            port_fault[p] = !port_legal[p]
                || (!secure && (port_bank[p] == BK_MON
                    || (port_bank[p] == BK_FIQ && fiq_lock_i)));
        end
    end

    // Write-only faults: PC index, misaligned SP outside the 32-bit set
    always_comb begin
        wr_fault = port_fault[P_WR] || port_pc[P_WR]
            || (wr_idx_i == IDX_SP && wr_data_i[1:0] != 2'b00
                && iset_i != ISET_WIDE);
    end

    assign wr_err_o = wr_en_i && wr_fault;

    brf_storage #(.DW(DW), .NREGS(PHYS_REGS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en_i && !wr_fault),
        .waddr_i (port_phys[P_WR]),
        .wdata_i (wr_data_i),
        .raddr_i (port_phys[P_RD]),
        .rdata_o (store_rdata)
    );

    brf_pc #(.DW(DW), .RESET_PC(RESET_PC)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_i      (pc_ld_i),
        .ld_addr_i (pc_ld_addr_i),
        .inc_i     (pc_inc_i),
        .narrow_i  (pc_narrow_i),
        .pc_o      (pc_o)
    );

    // Read result: PC with offset, zero on fault, else stored value
    always_comb begin
        if (port_pc[P_RD]) begin
            rd_err_o  = 1'b0;
            rd_data_o = pc_o + ((iset_i == ISET_WIDE) ? DW'(OFF_W) : DW'(OFF_N));
        end else begin
            rd_err_o  = port_fault[P_RD];
            rd_data_o = port_fault[P_RD] ? '0 : store_rdata;
        end
    end
endmodule

// File: rtl/brf_checks.sv
// Module: property checker for banked_regfile, attached by bind below.
// Assumes the same port names as the top; observes only.
module brf_checks #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sec_ext_i,
    input logic [1:0]    iset_i,
    input logic [3:0]    rd_idx_i,
    input logic [DW-1:0] rd_data_o,
    input logic          rd_err_o,
    input logic          wr_en_i,
    input logic [3:0]    wr_idx_i,
    input logic [4:0]    wr_mode_i,
    input logic [DW-1:0] wr_data_i,
    input logic          wr_err_o,
    input logic          pc_ld_i,
    input logic [DW-1:0] pc_ld_addr_i,
    input logic          pc_inc_i,
    input logic          pc_narrow_i,
    input logic [DW-1:0] pc_o
);
    logic mode_known;
    // Independent list of legal mode codes
    always_comb begin
        mode_known = wr_mode_i inside {5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                       5'b10110, 5'b10111, 5'b11011, 5'b11111};
    end

    assert_pc_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ld_i |=> pc_o == $past(pc_ld_addr_i));
    assert_pc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc_i && !pc_ld_i) |=>
            pc_o == $past(pc_o) + ($past(pc_narrow_i) ? DW'(2) : DW'(4)));
    assert_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_inc_i && !pc_ld_i) |=> $stable(pc_o));
    assert_pc_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_i == 4'd15) |->
            (!rd_err_o && rd_data_o == pc_o + ((iset_i == 2'b00) ? DW'(8) : DW'(4))));
    assert_pc_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == 4'd15) |-> wr_err_o);
    assert_zero_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err_o |-> rd_data_o == '0);
    assert_bad_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (!mode_known || (wr_mode_i == 5'b10110 && !sec_ext_i))) |-> wr_err_o);
    assert_sp_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == 4'd13 && wr_data_i[1:0] != 2'b00 && iset_i != 2'b00)
            |-> wr_err_o);
endmodule

bind banked_regfile brf_checks #(.DW(DW)) u_brf_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_ext_i    (sec_ext_i),
    .iset_i       (iset_i),
    .rd_idx_i     (rd_idx_i),
    .rd_data_o    (rd_data_o),
    .rd_err_o     (rd_err_o),
    .wr_en_i      (wr_en_i),
    .wr_idx_i     (wr_idx_i),
    .wr_mode_i    (wr_mode_i),
    .wr_data_i    (wr_data_i),
    .wr_err_o     (wr_err_o),
    .pc_ld_i      (pc_ld_i),
    .pc_ld_addr_i (pc_ld_addr_i),
    .pc_inc_i     (pc_inc_i),
    .pc_narrow_i  (pc_narrow_i),
    .pc_o         (pc_o)
);

// File: tb/banked_regfile_bench.sv
// Bench: directed corner cases plus seeded random traffic against a model
// built from the requirements.
module banked_regfile_bench;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sec_ext_i = 1'b1, ns_i = 1'b0, fiq_lock_i = 1'b0;
    logic [4:0]    cur_mode_i = 5'b10011;
    logic [1:0]    iset_i = 2'b00;
    logic [3:0]    rd_idx_i = '0, wr_idx_i = '0;
    logic [4:0]    rd_mode_i = 5'b10000, wr_mode_i = 5'b10000;
    logic [DW-1:0] rd_data_o, wr_data_i = '0, pc_ld_addr_i = '0, pc_o;
    logic          rd_err_o, wr_err_o;
    logic          wr_en_i = 1'b0, pc_ld_i = 1'b0, pc_inc_i = 1'b0, pc_narrow_i = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    logic [DW-1:0] m_reg [32];
    logic [DW-1:0] m_pc;

    always #4 clk = ~clk;   // 125 MHz

    banked_regfile u_banked_regfile (.*);

    function automatic bit mode_ok(logic [4:0] m, logic ext);
        case (m)
            5'b10000, 5'b10001, 5'b10010, 5'b10011,
            5'b10111, 5'b11011, 5'b11111: return 1'b1;
            5'b10110: return ext;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic int owner(logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            5'b10110: return 6;
            default:  return 0;
        endcase
    endfunction

    function automatic int slot(logic [3:0] i, logic [4:0] m);
        if (i < 8) return int'(i);
        if (i <= 12) return (m == 5'b10001) ? int'(i) + 5 : int'(i);
        return 18 + 2 * owner(m) + int'(i) - 13;
    endfunction

    function automatic bit mode_fault(logic [4:0] m);
        bit sec = !sec_ext_i || !ns_i || cur_mode_i == 5'b10110;
        return !mode_ok(m, sec_ext_i)
            || (!sec && (m == 5'b10110 || (m == 5'b10001 && fiq_lock_i)));
    endfunction

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Called right after a negedge with inputs set; checks, then models the edge.
    task automatic step(string tag);
        logic [DW-1:0] e_rd;
        bit e_rerr, e_wf;
        #1;
        if (rd_idx_i == 4'd15) begin
            e_rerr = 1'b0;
            e_rd = m_pc + ((iset_i == 2'b00) ? 32'd8 : 32'd4);
        end else begin
            e_rerr = mode_fault(rd_mode_i);
            e_rd = e_rerr ? '0 : m_reg[slot(rd_idx_i, rd_mode_i)];
        end
        e_wf = mode_fault(wr_mode_i) || wr_idx_i == 4'd15
            || (wr_idx_i == 4'd13 && wr_data_i[1:0] != 2'b00 && iset_i != 2'b00);
        chk(tag, "rd_data", rd_data_o, e_rd);
        chk(tag, "rd_err", DW'(rd_err_o), DW'(e_rerr));
        chk(tag, "wr_err", DW'(wr_err_o), DW'(wr_en_i && e_wf));
        chk(tag, "pc", pc_o, m_pc);
        if (wr_en_i && !e_wf) m_reg[slot(wr_idx_i, wr_mode_i)] = wr_data_i;
        if (pc_ld_i) m_pc = pc_ld_addr_i;
        else if (pc_inc_i) m_pc = m_pc + (pc_narrow_i ? 32'd2 : 32'd4);
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] i, logic [4:0] m, logic [DW-1:0] d, string tag);
        wr_en_i = 1'b1; wr_idx_i = i; wr_mode_i = m; wr_data_i = d;
        step(tag);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(logic [3:0] i, logic [4:0] m, string tag);
        rd_idx_i = i; rd_mode_i = m;
        step(tag);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [4:0] legal_modes [8];
        void'($urandom(32'd20240611));
        legal_modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                        5'b10110, 5'b10111, 5'b11011, 5'b11111};
        for (int k = 0; k < 32; k++) m_reg[k] = '0;
        m_pc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        rd(4'd5, 5'b10000, "R11");
        rd(4'd13, 5'b10011, "R11");
        // R2: shared low registers
        wr(4'd2, 5'b10010, 32'h0000_0055, "R2");
        rd(4'd2, 5'b10111, "R2");
        // R3: fast-interrupt copy of 8..12
        wr(4'd9, 5'b10001, 32'h0000_00AA, "R3");
        rd(4'd9, 5'b10010, "R3");
        rd(4'd9, 5'b10001, "R3");
        // R4: per-mode SP/LR, system shares user
        wr(4'd13, 5'b10011, 32'h0000_0100, "R4");
        wr(4'd13, 5'b10000, 32'h0000_0200, "R4");
        wr(4'd14, 5'b11011, 32'h0000_0301, "R4");
        rd(4'd13, 5'b10011, "R4");
        rd(4'd13, 5'b11111, "R4");
        rd(4'd14, 5'b11011, "R4");
        // R5: PC reads and PC-index writes
        wr(4'd15, 5'b10000, 32'h1234_5678, "R5");
        iset_i = 2'b00; rd(4'd15, 5'b10000, "R5");
        iset_i = 2'b01; rd(4'd15, 5'b10000, "R5");
        iset_i = 2'b00;
        // R1: bad mode codes
        rd(4'd3, 5'b10100, "R1");
        wr(4'd3, 5'b00000, 32'h1, "R1");
        sec_ext_i = 1'b0; rd(4'd13, 5'b10110, "R1"); sec_ext_i = 1'b1;
        // R6 and R8: non-secure restrictions, suppressed write
        ns_i = 1'b1; cur_mode_i = 5'b10000; fiq_lock_i = 1'b1;
        wr(4'd9, 5'b10001, 32'hDEAD_BEEF, "R6");
        rd(4'd13, 5'b10110, "R6");
        ns_i = 1'b0; fiq_lock_i = 1'b0;
        rd(4'd9, 5'b10001, "R8");
        // R7: SP alignment
        iset_i = 2'b01; wr(4'd13, 5'b10011, 32'h0000_0102, "R7");
        rd(4'd13, 5'b10011, "R7");
        iset_i = 2'b00; wr(4'd13, 5'b10011, 32'h0000_0102, "R7");
        rd(4'd13, 5'b10011, "R7");
        // R9: write and read of the same slot in one cycle
        rd_idx_i = 4'd4; rd_mode_i = 5'b10000;
        wr(4'd4, 5'b10011, 32'hCAFE_0004, "R9");
        rd(4'd4, 5'b10000, "R9");
        // R10: load beats increment, then narrow and wide steps
        pc_ld_i = 1'b1; pc_inc_i = 1'b1; pc_ld_addr_i = 32'h0000_8000;
        rd_idx_i = 4'd15; step("R10");
        pc_ld_i = 1'b0; pc_narrow_i = 1'b1; step("R10");
        pc_narrow_i = 1'b0; step("R10");
        pc_inc_i = 1'b0; step("R10");

        // Random traffic
        for (int v = 0; v < 3000; v++) begin
            sec_ext_i   = ($urandom % 10) != 0;
            ns_i        = ($urandom % 4) == 0;
            cur_mode_i  = legal_modes[$urandom % 8];
            fiq_lock_i  = $urandom % 2;
            iset_i      = 2'($urandom);
            rd_idx_i    = 4'($urandom);
            rd_mode_i   = (($urandom % 10) < 9) ? legal_modes[$urandom % 8] : 5'($urandom);
            wr_en_i     = $urandom % 2;
            wr_idx_i    = 4'($urandom);
            wr_mode_i   = (($urandom % 10) < 9) ? legal_modes[$urandom % 8] : 5'($urandom);
            wr_data_i   = $urandom;
            if ($urandom % 2) wr_data_i[1:0] = 2'b00;
            pc_ld_i     = ($urandom % 8) == 0;
            pc_ld_addr_i = $urandom;
            pc_inc_i    = $urandom % 2;
            pc_narrow_i = $urandom % 2;
            step("R9-random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule